// File: doc/BRIEF.md
# Packet-Wide Asynchronous Serial Link

This block moves one whole 128-bit word at a time between two neighbouring nodes on the same chip over a single wire in each direction of travel. A node owns one transmitter, which drives the wire toward the next node, and one receiver, which listens to the wire coming from the previous node. Traffic on a wire only ever flows one way.

A frame has three parts. A single low start bit comes first. The data word follows with its least significant bit first. A single high stop bit ends the frame. There is no parity bit, and the frame lasts 130 bit times. The system clock serves directly as the 16x oversampling clock, so each bit lasts 16 clock cycles. Only the start bit resynchronises the receiver, so the clocks at the two ends must agree to within roughly 0.1 percent.

The transmitter accepts a word through a valid/ready handshake and shifts it out. The receiver passes the incoming line through a two-flop synchroniser, looks for the falling edge of a start bit, and samples every bit at its middle. It then delivers either the word with a one-cycle valid strobe or a one-cycle framing-error flag.

Top module: `pkt_serial_link`

## Requirements
- R1: After reset and whenever the transmitter is idle, the transmit line is 1 and the transmitter is ready. The receiver outputs rx_valid and rx_frame_err are 0 after reset.
- R2: A word accepted when tx_valid and tx_ready are both 1 at a clock edge goes out on tx_line starting at that edge. The start bit is 0 for 16 cycles. The 128 data bits follow, bit 0 first, each held for 16 cycles. The stop bit is 1 for 16 cycles.
- R3: tx_ready is 0 from the edge that accepts a word until the end of the stop bit, which is 2080 cycles after acceptance.
- R4: tx_done is 1 for exactly one cycle, beginning 2080 cycles after the accepting edge, and tx_ready is 1 in that same cycle.
- R5: tx_valid has no effect while tx_ready is 0. No second frame starts and no extra word reaches the far end.
- R6: A frame on rx_line with stop bit 1 yields a one-cycle rx_valid pulse with rx_data equal to the sent word. rx_data changes only together with rx_valid.
- R7: A frame whose stop bit samples as 0 raises rx_frame_err for one cycle. In that case rx_valid stays 0 and rx_data keeps its previous value.
- R8: A low pulse on rx_line shorter than half a bit is not taken as a start bit. It causes neither rx_valid nor rx_frame_err, and a valid frame that follows is still received.
- R9: Words presented back to back are accepted as soon as tx_ready returns, and each one is delivered in order at the far end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the 16x bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 128 | Word to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmitter can accept a word |
| tx_done | output | 1 | One-cycle pulse after a stop bit has been sent |
| tx_line | output | 1 | Serial line toward the next node |
| rx_line | input | 1 | Serial line from the previous node |
| rx_data | output | 128 | Last word received without error |
| rx_valid | output | 1 | One-cycle pulse when rx_data is updated |
| rx_frame_err | output | 1 | One-cycle pulse on a bad stop bit |

## Verification
The assertions check the per-cycle properties on every cycle. The line is high whenever the transmitter is ready. An accepted word pulls the line low and drops ready on the next cycle. The done, valid and error strobes each last a single cycle, and valid and error never occur together. The received word never changes without valid. The scenarios in the bench cover the rest: the exact bit order and bit timing sampled at mid-bit, the 2080-cycle frame length, rejection of a short glitch, discarding of a frame with a bad stop bit, and in-order delivery of back-to-back words through a loopback.

// File: rtl/pkt_link_pkg.sv
package pkt_link_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_DATA, PH_STOP} phase_t;

  // last oversampling tick of one bit period
  function automatic bit tick_last(int unsigned c, int unsigned ovs);
    return c == ovs - 1;
  endfunction

  // tick at which the start bit is confirmed (middle of the bit)
  function automatic int unsigned mid_tick(int unsigned ovs);
    return ovs / 2 - 1;
  endfunction
endpackage

// File: rtl/pkt_link_sync.sv
module pkt_link_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1, s2;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end
  assign q = s2;
endmodule

// File: rtl/pkt_link_tx.sv
module pkt_link_tx
  import pkt_link_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data,
  input  logic              valid,
  output logic              ready,
  output logic              done,
  output logic              line
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST_IDX = BW'(DATA_W - 1);

  phase_t            ph;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     idx;
  logic [DATA_W-1:0] sh;
  logic              line_q, done_q;
  logic              accept, tick_end;

  assign ready    = (ph == PH_IDLE);
  assign accept   = valid && ready;
  assign tick_end = tick_last(int'(cnt), OVS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '0;
      line_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph)
        PH_IDLE: if (accept) begin
          ph     <= PH_START;
          cnt    <= '0;
          sh     <= data;
          line_q <= 1'b0;
        end
        PH_START: if (tick_end) begin
          ph     <= PH_DATA;
          cnt    <= '0;
          idx    <= '0;
          line_q <= sh[0];
        end else cnt <= cnt + 1'b1;
        PH_DATA: if (tick_end) begin
          cnt <= '0;
          if (idx == LAST_IDX) begin
            ph     <= PH_STOP;
            line_q <= 1'b1;
          end else begin
            idx    <= idx + 1'b1;
            sh     <= sh >> 1;
            line_q <= sh[1];
          end
        end else cnt <= cnt + 1'b1;
        PH_STOP: if (tick_end) begin
          ph     <= PH_IDLE;
          cnt    <= '0;
          done_q <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign line = line_q;
  assign done = done_q;

  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> line);
  a_r2_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !line);
  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);
endmodule

// File: rtl/pkt_link_rx.sv
module pkt_link_rx
  import pkt_link_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_s,
  output logic [DATA_W-1:0] data,
  output logic              valid,
  output logic              ferr
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST_IDX = BW'(DATA_W - 1);

  phase_t            ph;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     idx;
  logic [DATA_W-1:0] sh, data_q;
  logic              prev, valid_q, ferr_q;
  logic              fall, tick_end, at_mid;

  assign fall     = prev && !line_s;
  assign tick_end = tick_last(int'(cnt), OVS);
  assign at_mid   = (int'(cnt) == int'(mid_tick(OVS)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      data_q  <= '0;
      prev    <= 1'b1;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      prev    <= line_s;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      case (ph)
        PH_IDLE: if (fall) begin
          ph  <= PH_START;
          cnt <= '0;
        end
        PH_START: if (at_mid) begin
          cnt <= '0;
          idx <= '0;
          ph  <= line_s ? PH_IDLE : PH_DATA;
        end else cnt <= cnt + 1'b1;
        PH_DATA: if (tick_end) begin
          cnt <= '0;
          sh  <= {line_s, sh[DATA_W-1:1]};
          if (idx == LAST_IDX) ph <= PH_STOP;
          else idx <= idx + 1'b1;
        end else cnt <= cnt + 1'b1;
        PH_STOP: if (tick_end) begin
          cnt <= '0;
          ph  <= PH_IDLE;
          if (line_s) begin
            valid_q <= 1'b1;
            data_q  <= sh;
          end else ferr_q <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign data  = data_q;
  assign valid = valid_q;
  assign ferr  = ferr_q;

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(data));
  a_r7_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    ferr |=> !ferr);
  a_r7_err_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && ferr));
endmodule

// File: rtl/pkt_serial_link.sv
module pkt_serial_link #(
  parameter int DATA_W = 128,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_done,
  output logic              tx_line,
  input  logic              rx_line,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_frame_err
);
  logic rx_line_s;

  pkt_link_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .data(tx_data), .valid(tx_valid),
    .ready(tx_ready), .done(tx_done), .line(tx_line)
  );

  pkt_link_sync u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_line_s)
  );

  pkt_link_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .line_s(rx_line_s),
    .data(rx_data), .valid(rx_valid), .ferr(rx_frame_err)
  );
endmodule

// File: tb/sim_pkt_serial_link.sv
`timescale 1ns/1ps
module sim_pkt_serial_link;
  localparam int W = 128;
  localparam int BIT_T = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         tx_valid = 1'b0;
  logic         tx_ready, tx_done, tx_line;
  logic         rx_line;
  logic [W-1:0] rx_data;
  logic         rx_valid, rx_frame_err;
  logic         inj_sel = 1'b0;
  logic         inj_line = 1'b1;

  int checks = 0;
  int fails = 0;
  int got = 0;
  int sent = 0;
  int err_seen = 0;
  logic [W-1:0] expq[$];

  always #2.5 clk = ~clk;
  assign rx_line = inj_sel ? inj_line : tx_line;

  pkt_serial_link u0 (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_done(tx_done), .tx_line(tx_line),
    .rx_line(rx_line), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R6", "unexpected word", rx_data, '0);
        end else begin
          logic [W-1:0] e;
          e = expq.pop_front();
          got++;
          chk(rx_data == e, "R6", "received word", rx_data, e);
        end
      end
      if (rx_frame_err) err_seen++;
    end
  end

  // driver: returns half a cycle after the accepting edge
  task automatic send_word(input logic [W-1:0] w);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data  = w;
    tx_valid = 1'b1;
    expq.push_back(w);
    sent++;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic inject_frame(input logic [W-1:0] w, input logic stop_bit);
    inj_line = 1'b0;
    repeat (BIT_T) @(negedge clk);
    for (int i = 0; i < W; i++) begin
      inj_line = w[i];
      repeat (BIT_T) @(negedge clk);
    end
    inj_line = stop_bit;
    repeat (BIT_T) @(negedge clk);
    inj_line = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_drain();
    for (int k = 0; k < 3000 && expq.size() != 0; k++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [W-1:0] w1, held;
    int e0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_ready == 1'b1, "R1", "ready after reset", W'(tx_ready), W'(1));
    chk(tx_line == 1'b1, "R1", "idle line", W'(tx_line), W'(1));
    chk(rx_valid == 1'b0 && rx_frame_err == 1'b0, "R1", "rx strobes",
        W'({rx_valid, rx_frame_err}), '0);

    // R2/R3/R4: probe a frame bit by bit
    w1 = {32'hDEADBEEF, 32'h0123_4567, 32'h89AB_CDEF, 32'hA5A5_0F0F};
    send_word(w1);
    repeat (8) @(negedge clk);
    chk(tx_line == 1'b0, "R2", "start bit", W'(tx_line), '0);
    chk(tx_ready == 1'b0, "R3", "busy in start bit", W'(tx_ready), '0);
    for (int i = 0; i < W; i++) begin
      repeat (BIT_T) @(negedge clk);
      chk(tx_line == w1[i], "R2", $sformatf("data bit %0d", i),
          W'(tx_line), W'(w1[i]));
    end
    repeat (BIT_T) @(negedge clk);
    chk(tx_line == 1'b1, "R2", "stop bit", W'(tx_line), W'(1));
    repeat (7) @(negedge clk);
    chk(tx_ready == 1'b0 && tx_done == 1'b0, "R3", "busy at end of stop",
        W'({tx_ready, tx_done}), '0);
    @(negedge clk);
    chk(tx_done == 1'b1 && tx_ready == 1'b1, "R4", "done with ready",
        W'({tx_ready, tx_done}), W'(3));
    @(negedge clk);
    chk(tx_done == 1'b0, "R4", "done one cycle", W'(tx_done), '0);
    wait_drain();
    chk(got == 1, "R6", "loopback count", W'(got), W'(1));

    // R5: valid while busy is ignored
    send_word({4{32'h1111_2222}});
    tx_data  = {4{32'hBAD0_BAD0}};
    tx_valid = 1'b1;
    repeat (200) @(negedge clk);
    chk(tx_ready == 1'b0, "R5", "still busy", W'(tx_ready), '0);
    tx_valid = 1'b0;
    wait_drain();
    repeat (100) @(negedge clk);
    chk(got == 2 && expq.size() == 0, "R5", "no extra word", W'(got), W'(2));

    // R9: back-to-back words
    send_word({4{32'hCAFE_F00D}});
    send_word('0);
    send_word('1);
    wait_drain();
    repeat (20) @(negedge clk);
    chk(got == 5, "R9", "back-to-back delivered", W'(got), W'(5));

    // R8: short glitch ignored, then a good injected frame
    inj_sel = 1'b1;
    repeat (4) @(negedge clk);
    e0 = err_seen;
    inj_line = 1'b0;
    repeat (4) @(negedge clk);
    inj_line = 1'b1;
    repeat (60) @(negedge clk);
    chk(got == 5 && err_seen == e0, "R8", "glitch no event",
        W'(got), W'(5));
    expq.push_back({4{32'h5A5A_C3C3}});
    sent++;
    inject_frame({4{32'h5A5A_C3C3}}, 1'b1);
    chk(got == 6, "R8", "frame after glitch", W'(got), W'(6));
    chk(rx_data == {4{32'h5A5A_C3C3}}, "R6", "rx_data held",
        rx_data, {4{32'h5A5A_C3C3}});

    // R7: bad stop bit
    held = rx_data;
    inject_frame({4{32'h7777_0001}}, 1'b0);
    repeat (10) @(negedge clk);
    chk(err_seen == e0 + 1, "R7", "frame error pulse",
        W'(err_seen), W'(e0 + 1));
    chk(got == 6, "R7", "no valid on error", W'(got), W'(6));
    chk(rx_data == held, "R7", "data kept", rx_data, held);

    // recovery after error
    expq.push_back({4{32'h0F0F_1234}});
    sent++;
    inject_frame({4{32'h0F0F_1234}}, 1'b1);
    chk(got == 7 && got == sent, "R6", "recovered after error",
        W'(got), W'(sent));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule